// File: doc/BRIEF.md
# Stream Cipher Message Framer

This block sits between a byte-wide message path and an external keystream generator. It encrypts or decrypts one message at a time. A message is started with a single load. The load carries a 128-bit key, a 32-bit frame counter, a 5-bit channel number, a direction flag and the message length in bits. From these values the block builds the four key words and the four initial-vector words the generator is seeded with, and it raises a one-cycle start pulse towards the generator.

The block then requests 32-bit keystream words one at a time. It splits each word into bytes, most significant byte first, and XORs each keystream byte with the byte arriving on the input stream. The result leaves on the output stream in the same cycle. When the bit length is not a whole number of bytes, the bits past the end of the message in the last output byte are cleared. A single-cycle done flag marks the end of the message.

The input stream stalls while a keystream word is outstanding and whenever the output stream is not ready. Encryption and decryption are the same operation.

Top module: `stream_cipher_framer`

## Requirements
- R1: `keyWords` is {K3,K2,K1,K0}, with K3 in bits 127:96. Each word Kn (n = 3 - i) is the big-endian join of key bytes 4i to 4i+3, where key byte b is `keyIn[127-8b -: 8]`. Key byte 0 therefore ends up in the top byte of K3.
- R2: `ivWords` is {V3,V2,V1,V0}, with V3 in bits 127:96. V3 and V1 both equal the count. V2 and V0 both hold the channel number in bits 31:27 and the direction in bit 26, with every other bit zero.
- R3: For a nonzero length, `genStart` is high for exactly one cycle per message, in the cycle after the load is accepted. `keyWords` and `ivWords` stay unchanged until the block is idle again.
- R4: A message of L bits takes exactly ceil(L/32) keystream word transfers. A transfer is a cycle with `ksReq` and `ksValid` both high.
- R5: Output byte j uses keystream word floor(j/4), at bits [31-8*(j mod 4) -: 8]. This means the most significant byte of each word is used first.
- R6: Each output byte equals the input byte XOR its keystream byte. A message of L bits transfers exactly ceil(L/8) bytes.
- R7: When L mod 8 = r is nonzero, the low 8-r bits of the last output byte are zero.
- R8: A load with length 0 raises `done` in the next cycle. No start pulse, no keystream request and no output byte appear for it.
- R9: `done` is a one-cycle pulse in the cycle after the last byte transfer. `loadReady` is high only while idle and returns in the cycle after `done`.
- R10: An input byte is consumed only together with an output transfer: `inReady` is never high while `outReady` is low. No byte moves while a keystream word is being requested.
- R11: During reset, `loadReady` is high and `genStart`, `ksReq`, `inReady`, `outValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Start a message with the parameters below |
| loadReady | output | 1 | Block is idle and accepts a load |
| keyIn | input | 128 | Key, byte 0 in bits 127:120 |
| countIn | input | 32 | Frame counter |
| bearerIn | input | 5 | Channel number |
| dirIn | input | 1 | Direction flag |
| bitLen | input | 32 | Message length in bits |
| keyWords | output | 128 | Key words for the generator |
| ivWords | output | 128 | Initial-vector words for the generator |
| genStart | output | 1 | Seed pulse to the generator |
| ksReq | output | 1 | Requests the next keystream word |
| ksValid | input | 1 | Keystream word available |
| ksWord | input | 32 | Keystream word |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted |
| inData | input | 8 | Input byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the output byte |
| outData | output | 8 | Processed byte |
| done | output | 1 | Message finished |

## Verification
The failures here show up in different places:

- A corrupted byte position or a stale keystream word shows up in the very next output byte. The bench reference model predicts every transferred byte.
- A wrong remaining-byte count has two visible effects. It either ends the message early, which raises `done` before all bytes have moved, or it overruns, which requests extra keystream words. The checker's word and byte counts catch both at the `done` cycle.
- A wrong tail mask appears only on the final byte of lengths that are not byte-aligned, which is why several such lengths are run.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef struct packed {
    logic load;
    logic takeWord;
    logic takeByte;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_FETCH,
    ST_RUN,
    ST_FIN
  } state_t;
endpackage

// File: rtl/sfu_datapath.sv
module sfu_datapath #(
  parameter int LEN_W  = 32,
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sfu_pkg::strobe_t     strobe,
  input  logic [127:0]         keyIn,
  input  logic [31:0]          countIn,
  input  logic [4:0]           bearerIn,
  input  logic                 dirIn,
  input  logic [LEN_W-1:0]     bitLen,
  input  logic [WORD_W-1:0]    ksWord,
  input  logic [7:0]           inData,
  output logic [127:0]         keyWords,
  output logic [127:0]         ivWords,
  output logic [7:0]           outData,
  output logic                 lenZero,
  output logic                 lastByte,
  output logic                 wordEnd
);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int IDX_W  = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;
  localparam int CNT_W  = LEN_W - 2;

  logic [127:0]        keyReg;
  logic [31:0]         countReg;
  logic [4:0]          bearerReg;
  logic                dirReg;
  logic [2:0]          tailBits;
  logic [CNT_W-1:0]    bytesLeft;
  logic [WORD_W-1:0]   wordReg;
  logic [IDX_W-1:0]    byteIdx;
  logic [CNT_W-1:0]    bytesNeeded;
  logic [7:0]          tailMask;
  logic [7:0]          ksByte;
  logic [31:0]         ivMid;

  // round the bit length up to whole bytes
  assign bytesNeeded = {2'b00, bitLen[LEN_W-1:3]} + CNT_W'(|bitLen[2:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg    <= '0;
      countReg  <= '0;
      bearerReg <= '0;
      dirReg    <= 1'b0;
      tailBits  <= '0;
      bytesLeft <= '0;
      wordReg   <= '0;
      byteIdx   <= '0;
    end else begin
      if (strobe.load) begin
        keyReg    <= keyIn;
        countReg  <= countIn;
        bearerReg <= bearerIn;
        dirReg    <= dirIn;
        tailBits  <= bitLen[2:0];
        bytesLeft <= bytesNeeded;
      end
      if (strobe.takeWord) begin
        wordReg <= ksWord;
        byteIdx <= '0;
      end else if (strobe.takeByte) begin
        wordReg   <= wordReg << 8;
        byteIdx   <= byteIdx + 1'b1;
        bytesLeft <= bytesLeft - 1'b1;
      end
    end
  end

  // Word n of the key (n = 3-i) is key bytes 4i..4i+3 big-endian; with key
  // byte 0 held at the top of keyReg this is the register taken in order.
  for (genvar i = 0; i < 4; i++) begin : gKeyWord
    assign keyWords[32*(3-i) +: 32] = keyReg[127-32*i -: 32];
  end

  assign ivMid   = {bearerReg, dirReg, 26'd0};
  assign ivWords = {countReg, ivMid, countReg, ivMid};

  assign ksByte   = wordReg[WORD_W-1 -: 8];
  assign tailMask = (tailBits == 3'd0) ? 8'hFF : ~(8'hFF >> tailBits);
  assign outData  = (inData ^ ksByte) & (lastByte ? tailMask : 8'hFF);

  assign lenZero  = (bitLen == '0);
  assign lastByte = (bytesLeft == CNT_W'(1));
  assign wordEnd  = (byteIdx == IDX_W'(BYTES_PER_WORD - 1));
endmodule

// File: rtl/sfu_ctrl.sv
module sfu_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic              inValid,
  input  logic              outReady,
  input  logic              ksValid,
  input  logic              lenZero,
  input  logic              lastByte,
  input  logic              wordEnd,
  output sfu_pkg::strobe_t  strobe,
  output logic              loadReady,
  output logic              genStart,
  output logic              ksReq,
  output logic              inReady,
  output logic              outValid,
  output logic              done
);
  import sfu_pkg::*;

  state_t state, stateNext;
  logic   byteGo;

  assign loadReady = (state == ST_IDLE);
  assign genStart  = (state == ST_INIT);
  assign ksReq     = (state == ST_FETCH);
  assign inReady   = (state == ST_RUN) && outReady;
  assign outValid  = (state == ST_RUN) && inValid;
  assign done      = (state == ST_FIN);
  assign byteGo    = (state == ST_RUN) && inValid && outReady;

  assign strobe.load     = loadValid && loadReady;
  assign strobe.takeWord = ksReq && ksValid;
  assign strobe.takeByte = byteGo;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (loadValid) stateNext = lenZero ? ST_FIN : ST_INIT;
      ST_INIT:  stateNext = ST_FETCH;
      ST_FETCH: if (ksValid) stateNext = ST_RUN;
      ST_RUN:   if (byteGo) begin
                  if (lastByte)     stateNext = ST_FIN;
                  else if (wordEnd) stateNext = ST_FETCH;
                end
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/stream_cipher_framer.sv
module stream_cipher_framer #(
  parameter int LEN_W  = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  output logic              loadReady,
  input  logic [127:0]      keyIn,
  input  logic [31:0]       countIn,
  input  logic [4:0]        bearerIn,
  input  logic              dirIn,
  input  logic [LEN_W-1:0]  bitLen,
  output logic [127:0]      keyWords,
  output logic [127:0]      ivWords,
  output logic              genStart,
  output logic              ksReq,
  input  logic              ksValid,
  input  logic [WORD_W-1:0] ksWord,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              done
);
  sfu_pkg::strobe_t strobe;
  logic lenZero, lastByte, wordEnd;

  sfu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .inValid(inValid),
    .outReady(outReady), .ksValid(ksValid), .lenZero(lenZero),
    .lastByte(lastByte), .wordEnd(wordEnd), .strobe(strobe),
    .loadReady(loadReady), .genStart(genStart), .ksReq(ksReq),
    .inReady(inReady), .outValid(outValid), .done(done)
  );

  sfu_datapath #(.LEN_W(LEN_W), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .keyIn(keyIn),
    .countIn(countIn), .bearerIn(bearerIn), .dirIn(dirIn), .bitLen(bitLen),
    .ksWord(ksWord), .inData(inData), .keyWords(keyWords),
    .ivWords(ivWords), .outData(outData), .lenZero(lenZero),
    .lastByte(lastByte), .wordEnd(wordEnd)
  );
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadValid,
  input logic             loadReady,
  input logic [LEN_W-1:0] bitLen,
  input logic [127:0]     keyWords,
  input logic [127:0]     ivWords,
  input logic             genStart,
  input logic             ksReq,
  input logic             ksValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic             done
);
  logic [LEN_W-1:0] wordCnt, byteCnt, expWords, expBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt  <= '0;
      byteCnt  <= '0;
      expWords <= '0;
      expBytes <= '0;
    end else if (loadValid && loadReady) begin
      wordCnt  <= '0;
      byteCnt  <= '0;
      expWords <= LEN_W'(bitLen[LEN_W-1:5]) + LEN_W'(|bitLen[4:0]);
      expBytes <= LEN_W'(bitLen[LEN_W-1:3]) + LEN_W'(|bitLen[2:0]);
    end else begin
      if (ksReq && ksValid)     wordCnt <= wordCnt + 1'b1;
      if (outValid && outReady) byteCnt <= byteCnt + 1'b1;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_after_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    genStart |-> $past(loadValid && loadReady));

  assert_seed_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReady && $past(!loadReady)) |-> ($stable(keyWords) && $stable(ivWords)));

  assert_empty_message_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadReady && bitLen == '0) |=> (done && !genStart && !ksReq));

  assert_flow_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && !outReady) && !(ksReq && (inReady || outValid)));

  assert_word_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wordCnt == expWords));

  assert_byte_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (byteCnt == expBytes));
endmodule

bind stream_cipher_framer sfu_checker #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadReady(loadReady),
  .bitLen(bitLen), .keyWords(keyWords), .ivWords(ivWords),
  .genStart(genStart), .ksReq(ksReq), .ksValid(ksValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .done(done)
);

// File: tb/stream_cipher_framer_tb_top.sv
module stream_cipher_framer_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         loadValid;
  logic         loadReady;
  logic [127:0] keyIn;
  logic [31:0]  countIn;
  logic [4:0]   bearerIn;
  logic         dirIn;
  logic [31:0]  bitLen;
  logic [127:0] keyWords, ivWords;
  logic         genStart, ksReq, ksValid;
  logic [31:0]  ksWord;
  logic         inValid, inReady;
  logic [7:0]   inData;
  logic         outValid, outReady;
  logic [7:0]   outData;
  logic         done;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  stream_cipher_framer dut_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadReady(loadReady),
    .keyIn(keyIn), .countIn(countIn), .bearerIn(bearerIn), .dirIn(dirIn),
    .bitLen(bitLen), .keyWords(keyWords), .ivWords(ivWords),
    .genStart(genStart), .ksReq(ksReq), .ksValid(ksValid), .ksWord(ksWord),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .done(done)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] genWord(input int seed, input int idx);
    return (32'(idx) * 32'h9E3779B9) ^ (32'(seed) * 32'h0101_0F0F) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [7:0] dataByte(input int seed, input int j);
    return 8'(j * 37 + seed * 11 + 5);
  endfunction

  // model of one output byte from the requirements
  function automatic logic [7:0] expByte(input int seed, input int len, input int j);
    logic [31:0] w;
    logic [7:0]  x;
    int nb;
    w  = genWord(seed, j / 4);
    x  = dataByte(seed, j) ^ w[31 - 8*(j % 4) -: 8];
    nb = (len + 7) / 8;
    if (j == nb - 1 && (len % 8) != 0) x = x & ~(8'hFF >> (len % 8));
    return x;
  endfunction

  task automatic runMsg(input int len, input int seed, input bit stall);
    logic [127:0] expKey, expIv;
    logic [31:0]  mid;
    int nb, ksIdx, oj, gens, lastCyc, cyc;
    bit seenDone;
    nb = (len + 7) / 8;
    @(negedge clk);
    keyIn    = {32'(seed) * 32'd3, 32'(seed) * 32'd5 + 1, 32'(seed) * 32'd7 + 2, 32'(seed) * 32'd11 + 3} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    countIn  = 32'(seed) * 32'h1357_9BDF;
    bearerIn = 5'(seed * 3 + 17);
    dirIn    = seed[0];
    bitLen   = 32'(len);
    loadValid = 1'b1;
    #1;
    chk(loadReady, "R9 idle before load", {127'd0, loadReady}, 1);
    @(negedge clk);
    loadValid = 1'b0;
    #1;
    if (len == 0) begin
      chk(done && !genStart && !ksReq && !outValid, "R8 empty message",
          {genStart, ksReq, outValid, done}, 4'b0001);
      @(negedge clk); #1;
      chk(!done && loadReady, "R9 idle after empty", {done, loadReady}, 2'b01);
      return;
    end
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 4; b++)
        expKey[32*(3-i) + 8*(3-b) +: 8] = keyIn[127 - 8*(4*i + b) -: 8];
    mid   = (32'(bearerIn) << 27) | (32'(dirIn) << 26);
    expIv = {countIn, mid, countIn, mid};
    chk(genStart, "R3 start pulse", {127'd0, genStart}, 1);
    chk(keyWords == expKey, "R1 key words", keyWords, expKey);
    chk(ivWords == expIv, "R2 iv words", ivWords, expIv);
    ksIdx = 0; oj = 0; gens = 1; lastCyc = -10; cyc = 0; seenDone = 0;
    while (!seenDone && cyc < 4000) begin
      @(negedge clk);
      ksValid  = stall ? ((cyc % 3) != 1) : 1'b1;
      ksWord   = genWord(seed, ksIdx);
      outReady = stall ? ((cyc % 4) != 2) : 1'b1;
      inValid  = (oj < nb) && (stall ? ((cyc % 5) != 3) : 1'b1);
      inData   = dataByte(seed, oj);
      #1;
      if (done) begin
        seenDone = 1;
        chk(oj == nb && lastCyc == cyc - 1, "R9 done timing",
            {64'(oj), 64'(lastCyc)}, {64'(nb), 64'(cyc - 1)});
      end else begin
        if (genStart) gens++;
        if (ksReq && ksValid) ksIdx++;
        if (inValid && !outReady)
          chk(!inReady && !outReady, "R10 stall holds input", {127'd0, inReady}, 0);
        if (outValid && outReady) begin
          chk(inReady, "R10 input taken with output", {127'd0, inReady}, 1);
          if (oj == nb - 1 && (len % 8) != 0)
            chk(outData == expByte(seed, len, oj), "R7 tail byte", outData, expByte(seed, len, oj));
          else
            chk(outData == expByte(seed, len, oj), "R5 R6 data byte", outData, expByte(seed, len, oj));
          oj++;
          lastCyc = cyc;
        end
      end
      cyc++;
    end
    if (!seenDone) chk(0, "R9 message never finished", 128'(oj), 128'(nb));
    chk(gens == 1, "R3 single start pulse", 128'(gens), 1);
    chk(ksIdx == (len + 31) / 32, "R4 keystream words", 128'(ksIdx), 128'((len + 31) / 32));
    ksValid = 1'b0; inValid = 1'b0; outReady = 1'b1;
    @(negedge clk); #1;
    chk(loadReady && !done, "R9 idle after done", {done, loadReady}, 2'b01);
  endtask

  initial begin
    #1_500_000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    loadValid = 1'b0; keyIn = '0; countIn = '0; bearerIn = '0; dirIn = 1'b0;
    bitLen = '0; ksValid = 1'b0; ksWord = '0; inValid = 1'b0; inData = '0;
    outReady = 1'b1;
    repeat (2) @(negedge clk);
    ksValid = 1'b1; inValid = 1'b1; loadValid = 1'b1;
    #1;
    chk(loadReady && !genStart && !ksReq && !inReady && !outValid && !done,
        "R11 reset outputs", {loadReady, genStart, ksReq, inReady, outValid, done}, 6'b100000);
    @(negedge clk);
    ksValid = 1'b0; inValid = 1'b0; loadValid = 1'b0;
    rstN = 1'b1;
    runMsg(0, 1, 0);
    runMsg(1, 2, 0);
    runMsg(8, 3, 0);
    runMsg(7, 4, 1);
    runMsg(32, 5, 0);
    runMsg(33, 6, 1);
    runMsg(100, 7, 1);
    runMsg(129, 8, 0);
    runMsg(256, 9, 1);
    runMsg(5, 10, 1);
    runMsg(0, 11, 0);
    runMsg(64, 12, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule